// File: doc/BRIEF.md
# Processor status longword unit

This block keeps the 32-bit processor status longword of a CPU core and maintains it as instructions retire. On each retire strobe it merges the ALU's negative, zero, overflow and carry results into the condition codes under a per-flag update mask. It raises an integer-overflow trap request when an overflowed instruction retires with the overflow trap enable on. It raises a trace trap request once for every instruction that started with the trace enable on. A pending bit inside the status word ensures that one such instruction yields exactly one trace trap.

It also tells the core whether a requested interrupt level beats the current priority level. A load port lets software write the unprivileged low byte at any time. The same port performs a full privileged load on exception return. A full load is refused if it would set compatibility mode, raise the priority level, or place ones in undefined bit positions. Dispatching the traps is left to the core.

Top module: `psl_unit`

## Requirements
- R1: After reset `psl_o` equals 32'h001F0000: priority level (bits 20:16) at its reset value 31, every other bit zero, and both trap outputs low.
- R2: On a cycle with `retire_i`=1 and no accepted load, each condition code whose bit in `cc_mask_i` is 1 takes the matching bit of `alu_flags_i`, and the other codes are kept; the layout is N=bit 3, Z=bit 2, V=bit 1, C=bit 0, the same in both inputs and in `psl_o`. Without `retire_i`, the codes do not change.
- R3: `ovf_trap_o` pulses high for one cycle, in the cycle after a retire with `int_ovf_i`=1, only when IV (bit 5) is 1 at that retire. With IV at 0, and for the stored FU bit (bit 6), no trap is raised.
- R4: An `issue_i` strobe while T (bit 4) is 1 sets trace pending (bit 30). The next `retire_i` clears it and pulses `trace_trap_o` in the following cycle. Repeated issue strobes before that retire still give one trap, and a retire with trace pending clear gives none.
- R5: `irq_take_o` is 1 exactly when `irq_req_i`=1 and `irq_level_i` is strictly greater than the current priority level (bits 20:16).
- R6: A load with `ld_valid_i`=1 and `ld_full_i`=0 is always accepted (`ld_ok_o`=1). It writes bits 7:0 from `ld_data_i` and ignores all other data bits. Bits 15:8 and 29:21 of `psl_o` always read zero.
- R7: A full load (`ld_full_i`=1) is accepted when all three of these hold: it does not set bit 31 while bit 31 is 0, its priority level is not above the current one, and its bits 29:21 and 15:8 are zero. An accepted full load writes bits 31, 30, 20:16 and 7:0.
- R8: A refused full load gives `ld_ok_o`=0 and leaves `psl_o` unchanged.
- R9: An accepted load in the same cycle as a retire takes precedence: the condition code update of that retire is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alu_flags_i | input | 4 | ALU result flags N,Z,V,C in bits 3..0 |
| cc_mask_i | input | 4 | Per-flag update enable, same layout |
| int_ovf_i | input | 1 | Retiring instruction produced an integer overflow |
| issue_i | input | 1 | An instruction starts this cycle |
| retire_i | input | 1 | An instruction completes this cycle |
| irq_req_i | input | 1 | Interrupt request present |
| irq_level_i | input | 5 | Level of the requested interrupt |
| irq_take_o | output | 1 | Request outranks the current priority level |
| ld_valid_i | input | 1 | Status load request |
| ld_full_i | input | 1 | 1: privileged full load, 0: low byte write |
| ld_data_i | input | 32 | Proposed status value |
| ld_ok_o | output | 1 | Load accepted |
| ovf_trap_o | output | 1 | Integer-overflow trap request pulse |
| trace_trap_o | output | 1 | Trace trap request pulse |
| psl_o | output | 32 | Current status longword |

## Verification
The condition code merge is driven by a vector table. Its mask patterns mix full update, single-flag update, no update and scattered bits, so a swapped flag position or a mask that is applied in reverse gives a wrong value. The interrupt compare is tried at equal and one-above levels to separate a strict comparison from a non-strict one. Full loads cover an accepted priority drop and three refusals, one for each rule. Together they show that each rule is checked on its own and that a refusal leaves the register intact. The trace sequence issues twice before a retire, and then retires again with nothing pending, so it can tell one trap from none or two.

// File: rtl/psl_pkg.sv
package psl_pkg;
  localparam int PSL_W   = 32;
  localparam int CC_W    = 4;
  localparam int LOW_W   = 8;
  localparam int IPL_W   = 5;
  localparam int IPL_LSB = 16;
  localparam int IPL_MSB = IPL_LSB + IPL_W - 1;
  localparam int T_BIT   = 4;
  localparam int IV_BIT  = 5;
  localparam int TP_BIT  = 30;
  localparam int CM_BIT  = 31;
  localparam int RSVD_W  = (TP_BIT - IPL_MSB - 1) + (IPL_LSB - LOW_W);
endpackage

// File: rtl/psl_cc_merge.sv
module psl_cc_merge
  import psl_pkg::*;
(
  input  logic [CC_W-1:0] cc_q_i,
  input  logic [CC_W-1:0] flags_i,
  input  logic [CC_W-1:0] mask_i,
  output logic [CC_W-1:0] cc_d_o
);
  for (genvar g = 0; g < CC_W; g++) begin : g_bit
    assign cc_d_o[g] = mask_i[g] ? flags_i[g] : cc_q_i[g];
  end
endmodule

// File: rtl/psl_trap_ctrl.sv
module psl_trap_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  input  logic retire_i,
  input  logic t_en_i,
  input  logic iv_en_i,
  input  logic int_ovf_i,
  input  logic tp_ld_i,
  input  logic tp_val_i,
  output logic tp_o,
  output logic ovf_trap_o,
  output logic trace_trap_o
);
  logic tp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tp_q         <= 1'b0;
      ovf_trap_o   <= 1'b0;
      trace_trap_o <= 1'b0;
    end else begin
      ovf_trap_o   <= retire_i & int_ovf_i & iv_en_i;
      trace_trap_o <= retire_i & tp_q;
      if (tp_ld_i) tp_q <= tp_val_i;
      else         tp_q <= (tp_q & ~retire_i) | (issue_i & t_en_i);
    end
  end

  assign tp_o = tp_q;
endmodule

// File: rtl/psl_load_check.sv
module psl_load_check
  import psl_pkg::*;
(
  input  logic              cur_cm_i,
  input  logic [IPL_W-1:0]  cur_ipl_i,
  input  logic              new_cm_i,
  input  logic [IPL_W-1:0]  new_ipl_i,
  input  logic [RSVD_W-1:0] new_rsvd_i,
  output logic              ok_o
);
  logic cm_raise, ipl_raise, undef;

  assign cm_raise  = new_cm_i & ~cur_cm_i;
  assign ipl_raise = new_ipl_i > cur_ipl_i;
  assign undef     = |new_rsvd_i;
  assign ok_o      = ~(cm_raise | ipl_raise | undef);
endmodule

// File: rtl/psl_unit.sv
module psl_unit
  import psl_pkg::*;
#(
  parameter logic [4:0] RESET_IPL = 5'd31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        alu_flags_i,
  input  logic [3:0]        cc_mask_i,
  input  logic              int_ovf_i,
  input  logic              issue_i,
  input  logic              retire_i,
  input  logic              irq_req_i,
  input  logic [4:0]        irq_level_i,
  output logic              irq_take_o,
  input  logic              ld_valid_i,
  input  logic              ld_full_i,
  input  logic [31:0]       ld_data_i,
  output logic              ld_ok_o,
  output logic              ovf_trap_o,
  output logic              trace_trap_o,
  output logic [31:0]       psl_o
);
  logic [LOW_W-1:0] low_q;
  logic [IPL_W-1:0] ipl_q;
  logic             cm_q;
  logic             tp;
  logic [CC_W-1:0]  cc_d;
  logic             full_ok, ld_acc, full_acc;
  logic [RSVD_W-1:0] new_rsvd;

  assign new_rsvd = {ld_data_i[TP_BIT-1:IPL_MSB+1], ld_data_i[IPL_LSB-1:LOW_W]};

  psl_cc_merge i_cc (
    .cc_q_i  (low_q[CC_W-1:0]),
    .flags_i (alu_flags_i),
    .mask_i  (cc_mask_i),
    .cc_d_o  (cc_d)
  );

  psl_load_check i_chk_ld (
    .cur_cm_i   (cm_q),
    .cur_ipl_i  (ipl_q),
    .new_cm_i   (ld_data_i[CM_BIT]),
    .new_ipl_i  (ld_data_i[IPL_MSB:IPL_LSB]),
    .new_rsvd_i (new_rsvd),
    .ok_o       (full_ok)
  );

  assign ld_ok_o  = ld_valid_i & (~ld_full_i | full_ok);
  assign ld_acc   = ld_ok_o;
  assign full_acc = ld_ok_o & ld_full_i;

  psl_trap_ctrl i_trap (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .issue_i      (issue_i),
    .retire_i     (retire_i),
    .t_en_i       (low_q[T_BIT]),
    .iv_en_i      (low_q[IV_BIT]),
    .int_ovf_i    (int_ovf_i),
    .tp_ld_i      (full_acc),
    .tp_val_i     (ld_data_i[TP_BIT]),
    .tp_o         (tp),
    .ovf_trap_o   (ovf_trap_o),
    .trace_trap_o (trace_trap_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q <= '0;
      ipl_q <= RESET_IPL;
      cm_q  <= 1'b0;
    end else if (ld_acc) begin
      low_q <= ld_data_i[LOW_W-1:0];
      if (ld_full_i) begin
        ipl_q <= ld_data_i[IPL_MSB:IPL_LSB];
        cm_q  <= ld_data_i[CM_BIT];
      end
    end else if (retire_i) begin
      low_q[CC_W-1:0] <= cc_d;
    end
  end

  assign irq_take_o = irq_req_i & (irq_level_i > ipl_q);

  always_comb begin
    psl_o                  = '0;
    psl_o[LOW_W-1:0]       = low_q;
    psl_o[IPL_MSB:IPL_LSB] = ipl_q;
    psl_o[TP_BIT]          = tp;
    psl_o[CM_BIT]          = cm_q;
  end
endmodule

// File: rtl/psl_unit_chk.sv
module psl_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [3:0]  alu_flags_i,
  input logic [3:0]  cc_mask_i,
  input logic        int_ovf_i,
  input logic        issue_i,
  input logic        retire_i,
  input logic        irq_req_i,
  input logic [4:0]  irq_level_i,
  input logic        irq_take_o,
  input logic        ld_valid_i,
  input logic        ld_full_i,
  input logic [31:0] ld_data_i,
  input logic        ld_ok_o,
  input logic        ovf_trap_o,
  input logic        trace_trap_o,
  input logic [31:0] psl_o
);
  p_cc_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!retire_i && !ld_valid_i) |=> $stable(psl_o[3:0]));

  p_ovf_trap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_trap_o |-> $past(retire_i && int_ovf_i && psl_o[5]));

  p_trace_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trace_trap_o |-> $past(retire_i && psl_o[30]));

  p_irq_top_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_o |-> (psl_o[20:16] != 5'd31));

  p_unused_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psl_o[15:8] == 8'h00) && (psl_o[29:21] == 9'h000));

  p_no_escalate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_ok_o && ld_full_i) |=> (psl_o[20:16] <= $past(psl_o[20:16])));

  p_refuse_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && ld_full_i && !ld_ok_o && !retire_i && !issue_i) |=> $stable(psl_o));
endmodule

bind psl_unit psl_unit_chk i_psl_unit_chk (.*);

// File: tb/test_psl_unit.sv
`timescale 1ns/1ps
module test_psl_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  alu_flags_i = '0, cc_mask_i = '0;
  logic        int_ovf_i = 0, issue_i = 0, retire_i = 0, irq_req_i = 0;
  logic [4:0]  irq_level_i = '0;
  logic        irq_take_o, ld_valid_i = 0, ld_full_i = 0, ld_ok_o;
  logic [31:0] ld_data_i = '0;
  logic        ovf_trap_o, trace_trap_o;
  logic [31:0] psl_o;
  int checks = 0, errors = 0;

  always #10 clk_i = ~clk_i;

  psl_unit i_psl_unit (.*);

  // flags, mask, expected condition codes
  localparam logic [11:0] VEC [0:5] = '{
    12'b1111_1111_1111, 12'b0000_0001_1110, 12'b0101_1100_0110,
    12'b1010_0000_0110, 12'b1001_1011_1101, 12'b0010_0011_1110 };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic idle();
    retire_i = 0; issue_i = 0; ld_valid_i = 0; ld_full_i = 0;
    int_ovf_i = 0; cc_mask_i = '0;
  endtask

  task automatic load(logic full, logic [31:0] d, logic exp_ok);
    ld_valid_i = 1; ld_full_i = full; ld_data_i = d; #1;
    chk(full ? "R7 ok" : "R6 ok", 32'(ld_ok_o), 32'(exp_ok));
    tick(); idle();
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    chk("R1 psl", psl_o, 32'h001F0000);
    chk("R1 traps", {30'd0, ovf_trap_o, trace_trap_o}, 32'd0);
    // R5 equal level not taken
    irq_req_i = 1; irq_level_i = 5'd31; #1;
    chk("R5 eq31", 32'(irq_take_o), 32'd0);
    irq_req_i = 0;
    // R6 low write, upper data ignored, FU stored
    load(1'b0, 32'hFFFF_FF40, 1'b1);
    chk("R6 low", psl_o, 32'h001F0040);
    // R2 vector table
    for (int i = 0; i < 6; i++) begin
      alu_flags_i = VEC[i][11:8]; cc_mask_i = VEC[i][7:4]; retire_i = 1;
      tick(); idle();
      chk("R2 cc", 32'(psl_o[3:0]), 32'(VEC[i][3:0]));
    end
    // R2 no retire, no change
    alu_flags_i = 4'h0; cc_mask_i = 4'hF; tick(); idle();
    chk("R2 hold", psl_o, 32'h001F004E);
    // R8 refusals
    load(1'b1, 32'h801F0000, 1'b0);
    chk("R8 cm", psl_o, 32'h001F004E);
    // R7 accepted priority drop
    load(1'b1, 32'h00080020, 1'b1);
    chk("R7 load", psl_o, 32'h00080020);
    load(1'b1, 32'h00090000, 1'b0);
    chk("R8 ipl", psl_o, 32'h00080020);
    load(1'b1, 32'h00081000, 1'b0);
    chk("R8 undef", psl_o, 32'h00080020);
    // R5 strict compare
    irq_req_i = 1; irq_level_i = 5'd8; #1;
    chk("R5 eq8", 32'(irq_take_o), 32'd0);
    irq_level_i = 5'd9; #1;
    chk("R5 gt", 32'(irq_take_o), 32'd1);
    irq_req_i = 0; #1;
    chk("R5 noreq", 32'(irq_take_o), 32'd0);
    // R3 overflow trap
    retire_i = 1; int_ovf_i = 1; tick(); idle();
    chk("R3 trap", 32'(ovf_trap_o), 32'd1);
    tick();
    chk("R3 pulse", 32'(ovf_trap_o), 32'd0);
    load(1'b0, 32'h00000040, 1'b1);
    retire_i = 1; int_ovf_i = 1; tick(); idle();
    chk("R3 iv off", 32'(ovf_trap_o), 32'd0);
    // R4 trace
    load(1'b0, 32'h00000010, 1'b1);
    issue_i = 1; tick(); idle();
    chk("R4 tp set", 32'(psl_o[30]), 32'd1);
    issue_i = 1; tick(); idle();
    chk("R4 trap early", 32'(trace_trap_o), 32'd0);
    retire_i = 1; tick(); idle();
    chk("R4 trap", 32'(trace_trap_o), 32'd1);
    chk("R4 tp clr", 32'(psl_o[30]), 32'd0);
    retire_i = 1; tick(); idle();
    chk("R4 once", 32'(trace_trap_o), 32'd0);
    load(1'b0, 32'h00000000, 1'b1);
    issue_i = 1; tick(); idle();
    retire_i = 1; tick(); idle();
    chk("R4 t off", 32'(trace_trap_o), 32'd0);
    // R9 load wins over retire
    alu_flags_i = 4'hF; cc_mask_i = 4'hF; retire_i = 1;
    load(1'b0, 32'h00000003, 1'b1);
    chk("R9 prio", psl_o, 32'h00080003);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule